// File: doc/BRIEF.md
# Interrupt-Driven Thread Dispatch Sequencer

This block is the control unit that sits in front of a small RISC coprocessor. It decides when a software thread starts, when one is preempted, when a preempted one resumes and when the core goes idle. Threads are launched by request pulses on a set of channels, and each channel has a configurable 3-bit priority. A larger number means a more urgent request. The instruction decoder and ALU are not part of this block. The execution core is modelled as a plain handshake: the sequencer issues a start pulse together with the initial program counter, the data pointer and the first opcode. The core then reports instruction boundaries and the end of its thread.

Starting a thread takes three word reads over a valid/ready bus master port. The first read fetches the entry address from the channel's vector slot. The second fetches the initial data pointer from the same slot. The third fetches the first opcode at the entry address. The vector slot of channel `c` sits at `vec_base + 4*c`, with the entry address at offset 0 and the data pointer at offset 2. Back-pressure rules on the port:
- The sequencer holds `bus_valid` and `bus_addr` steady until it samples `bus_ready` high on a rising edge.
- Read data is taken in that same cycle.
- Each low cycle of `bus_ready` adds one wait state to the access.

A running thread can be preempted, at an instruction boundary, by a pending request of strictly higher priority. The context of the preempted thread is pushed onto an internal stack: the boundary program counter, the data pointer and the thread's priority. When a thread ends, the sequencer compares the best pending request with the most recently preempted context. The more urgent of the two runs next, and on a tie the saved context wins. Resuming a saved context costs a single opcode re-fetch and no vector reads.

Top module: `thread_dispatch_seq`

## Requirements
- R1: A new thread performs exactly three reads, in this order: `vec_base+4*ch`, which loads the PC; `vec_base+4*ch+2`, which loads the data pointer; and the loaded PC, which loads the opcode. One cycle after the opcode read completes, `core_start` pulses high for one cycle with `core_pc`, `core_r1` and `core_opcode` holding the three words. With no wait states, `core_start` is seen on the 4th falling edge after the cycle in which the request became pending.
- R2: Every bus address is even. `bus_valid` and `bus_addr` stay unchanged while `bus_ready` is low. Each wait cycle lengthens the access by one cycle, so with 2 wait states per access a thread start takes 10 falling edges.
- R3: Among pending channels, the highest priority is chosen, and on a tie the lowest channel index wins. `dispatch_ack` is a one-hot pulse, with bit `ch` set, in the cycle that the choice is made, and that channel's pending flag is cleared.
- R4: When `core_boundary` is high, `core_end` is low, and a pending request has a priority strictly greater than `cur_prio`, the running thread is saved and the vector read for the new request starts on the next cycle. A pending request of equal or lower priority causes no bus access and leaves the core running.
- R5: Resuming a saved context performs a single read at the saved PC. It then pulses `core_start` with the saved PC and data pointer, and restores `cur_prio` to the saved priority.
- R6: At thread end, a new vector fetch starts if the best pending priority is strictly greater than the priority of the most recently saved context, or if no context is saved. Otherwise the saved context resumes.
- R7: At thread end, with nothing pending and no saved context, `idle` is high on the next cycle and the bus stays quiet.
- R8: After reset, `idle` is 1 and `bus_valid`, `core_start`, `core_run` and `cur_prio` are 0.
- R9: The context stack holds one entry per priority level. Nested preemption through every level saves each context and restores it in last-in, first-out order, and a push never meets a full stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse | input | N_CH | One-cycle request pulses, one per channel |
| req_prio | input | N_CH*PRIO_W | Priority of each channel; channel c uses bits [c*PRIO_W +: PRIO_W] |
| vec_base | input | WORD_W | Base address of the vector table |
| bus_valid | output | 1 | Read request valid |
| bus_addr | output | WORD_W | Word-aligned read address |
| bus_ready | input | 1 | Read completes on a rising edge where this is high |
| bus_rdata | input | WORD_W | Read data, valid while bus_ready is high |
| core_start | output | 1 | One-cycle pulse that launches or resumes the core |
| core_pc | output | WORD_W | Program counter handed to the core |
| core_r1 | output | WORD_W | Data pointer handed to the core |
| core_opcode | output | WORD_W | Opcode handed to the core |
| core_run | output | 1 | Core owns execution |
| core_boundary | input | 1 | Core is at an instruction boundary |
| core_pc_now | input | WORD_W | Core PC at the boundary |
| core_r1_now | input | WORD_W | Core data pointer at the boundary |
| core_end | input | 1 | Core executed its return-from-thread |
| dispatch_ack | output | N_CH | One-hot pulse on the channel being dispatched |
| idle | output | 1 | No thread running or being started |
| cur_prio | output | PRIO_W | Priority of the current thread |

## Verification
The bench goes after the points where priority is compared. It checks a tie between two equal channels, where a wrong tie-break would dispatch the higher channel index first. It checks an equal-priority request at a boundary, where a non-strict compare would preempt. It checks a thread end with a pending request below the saved context, where a design that ignored the stack would start the lower request before resuming. It also checks a pending request above the saved context, where a design that always resumed would hold the urgent request back. A resume is checked to make exactly one read at the saved PC, so a design that re-ran the vector fetch would show extra accesses and the wrong entry PC. Wait states of two cycles per access are used to catch address drift or early data capture. A nest of eight levels checks that contexts unwind in reverse order with their own PC and priority.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_VEC_PC = 3'd1,
    ST_VEC_R1 = 3'd2,
    ST_OPC    = 3'd3,
    ST_RUN    = 3'd4
  } tds_state_e;

  function automatic logic [15:0] align_word(input logic [15:0] a);
    return {a[15:1], 1'b0};
  endfunction
endpackage

// File: rtl/tds_arbiter.sv
module tds_arbiter #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 3,
  parameter int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]        pend,
  input  logic [N_CH*PRIO_W-1:0] prio_flat,
  output logic                   any,
  output logic [CH_W-1:0]        best_ch,
  output logic [PRIO_W-1:0]      best_prio
);
  // Scan upward; a strictly greater priority replaces the holder,
  // so the lowest index keeps a tie.
  always_comb begin
    any       = 1'b0;
    best_ch   = '0;
    best_prio = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (pend[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
        any       = 1'b1;
        best_ch   = CH_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tds_ctx_stack.sv
module tds_ctx_stack #(
  parameter int W     = 35,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = IDX_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign top   = empty ? '0 : mem[IDX_W'(cnt_q - 1'b1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[g] <= '0;
        end else if (push && !full && IDX_W'(cnt_q) == IDX_W'(g)) begin
          mem[g] <= din;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/thread_dispatch_seq.sv
module thread_dispatch_seq #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 3,
  parameter int WORD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        req_pulse,
  input  logic [N_CH*PRIO_W-1:0] req_prio,
  input  logic [WORD_W-1:0]      vec_base,
  output logic                   bus_valid,
  output logic [WORD_W-1:0]      bus_addr,
  input  logic                   bus_ready,
  input  logic [WORD_W-1:0]      bus_rdata,
  output logic                   core_start,
  output logic [WORD_W-1:0]      core_pc,
  output logic [WORD_W-1:0]      core_r1,
  output logic [WORD_W-1:0]      core_opcode,
  output logic                   core_run,
  input  logic                   core_boundary,
  input  logic [WORD_W-1:0]      core_pc_now,
  input  logic [WORD_W-1:0]      core_r1_now,
  input  logic                   core_end,
  output logic [N_CH-1:0]        dispatch_ack,
  output logic                   idle,
  output logic [PRIO_W-1:0]      cur_prio
);
  import tds_pkg::*;

  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int CTX_W = 2 * WORD_W + PRIO_W;
  localparam int DEPTH = 1 << PRIO_W;

  tds_state_e        state_q;
  logic [WORD_W-1:0] addr_q, pc_q, r1_q, op_q;
  logic [PRIO_W-1:0] prio_q;
  logic              start_q;
  logic [N_CH-1:0]   pend_q;

  logic              any_pend;
  logic [CH_W-1:0]   best_ch;
  logic [PRIO_W-1:0] best_prio;
  logic              in_run, take_new, preempt, do_resume;
  logic              stk_push, stk_pop, stk_empty, stk_full;
  logic [CTX_W-1:0]  stk_din, stk_top;
  logic [WORD_W-1:0] top_pc, top_r1;
  logic [PRIO_W-1:0] top_prio;
  logic [WORD_W-1:0] vec_addr;

  tds_arbiter #(.N_CH(N_CH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_arb (
    .pend      (pend_q),
    .prio_flat (req_prio),
    .any       (any_pend),
    .best_ch   (best_ch),
    .best_prio (best_prio)
  );

  tds_ctx_stack #(.W(CTX_W), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   (stk_din),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  assign {top_pc, top_r1, top_prio} = stk_top;
  assign vec_addr = vec_base + (WORD_W'(best_ch) << 2);

  // Decisions for the current cycle.
  always_comb begin
    in_run    = (state_q == ST_RUN);
    preempt   = in_run && !core_end && core_boundary && any_pend && (best_prio > prio_q);
    take_new  = 1'b0;
    do_resume = 1'b0;
    if (state_q == ST_IDLE) begin
      take_new = any_pend;
    end else if (in_run && core_end) begin
      take_new  = any_pend && (stk_empty || best_prio > top_prio);
      do_resume = !take_new && !stk_empty;
    end else begin
      take_new = preempt;
    end
  end

  assign stk_push = preempt;
  assign stk_pop  = do_resume;
  assign stk_din  = {WORD_W'(align_word(16'(core_pc_now))), core_r1_now, prio_q};

  always_comb begin
    dispatch_ack = '0;
    if (take_new) dispatch_ack[best_ch] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | req_pulse) & ~dispatch_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pc_q    <= '0;
      r1_q    <= '0;
      op_q    <= '0;
      prio_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_RUN: begin
          if (take_new) begin
            state_q <= ST_VEC_PC;
            addr_q  <= WORD_W'(align_word(16'(vec_addr)));
            prio_q  <= best_prio;
          end else if (do_resume) begin
            state_q <= ST_OPC;
            pc_q    <= top_pc;
            r1_q    <= top_r1;
            prio_q  <= top_prio;
            addr_q  <= top_pc;
          end else if (in_run && core_end) begin
            state_q <= ST_IDLE;
          end
        end
        ST_VEC_PC: if (bus_ready) begin
          pc_q    <= WORD_W'(align_word(16'(bus_rdata)));
          addr_q  <= addr_q + WORD_W'(2);
          state_q <= ST_VEC_R1;
        end
        ST_VEC_R1: if (bus_ready) begin
          r1_q    <= bus_rdata;
          addr_q  <= pc_q;
          state_q <= ST_OPC;
        end
        ST_OPC: if (bus_ready) begin
          op_q    <= bus_rdata;
          start_q <= 1'b1;
          state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid   = (state_q == ST_VEC_PC) || (state_q == ST_VEC_R1) || (state_q == ST_OPC);
  assign bus_addr    = addr_q;
  assign core_start  = start_q;
  assign core_pc     = pc_q;
  assign core_r1     = r1_q;
  assign core_opcode = op_q;
  assign core_run    = in_run;
  assign idle        = (state_q == ST_IDLE);
  assign cur_prio    = prio_q;
endmodule

// File: rtl/tds_checker.sv
module tds_checker #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 3,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [WORD_W-1:0] bus_addr,
  input logic              idle,
  input logic              core_start,
  input logic              core_boundary,
  input logic              core_end,
  input logic              in_run,
  input logic [N_CH-1:0]   dispatch_ack,
  input logic [PRIO_W-1:0] best_prio,
  input logic [PRIO_W-1:0] cur_prio,
  input logic              stk_push,
  input logic              stk_full
);
  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  assert_addr_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[0] == 1'b0));

  assert_hold_on_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dispatch_ack));

  assert_preempt_higher_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && core_boundary && !core_end && (|dispatch_ack)) |-> (best_prio > cur_prio));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !bus_valid);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |-> !stk_full);
endmodule

bind thread_dispatch_seq tds_checker #(.N_CH(N_CH), .PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid     (bus_valid),
  .bus_ready     (bus_ready),
  .bus_addr      (bus_addr),
  .idle          (idle),
  .core_start    (core_start),
  .core_boundary (core_boundary),
  .core_end      (core_end),
  .in_run        (in_run),
  .dispatch_ack  (dispatch_ack),
  .best_prio     (best_prio),
  .cur_prio      (cur_prio),
  .stk_push      (stk_push),
  .stk_full      (stk_full)
);

// File: tb/thread_dispatch_seq_bench.sv
`timescale 1ns/1ps
module thread_dispatch_seq_bench;
  localparam int N_CH = 8;
  localparam int PW   = 3;
  localparam int WW   = 16;
  localparam logic [15:0] BASE = 16'h0100;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N_CH-1:0]    req_pulse = '0;
  logic [N_CH*PW-1:0] req_prio = '0;
  logic          bus_valid, bus_ready = 0;
  logic [WW-1:0] bus_addr, bus_rdata = '0;
  logic          core_start, core_run, idle;
  logic [WW-1:0] core_pc, core_r1, core_opcode;
  logic          core_boundary = 0, core_end = 0;
  logic [WW-1:0] core_pc_now = '0, core_r1_now = '0;
  logic [N_CH-1:0] dispatch_ack;
  logic [PW-1:0] cur_prio;

  int tests = 0, fails = 0, wait_n = 0, wcnt = 0;
  logic [15:0] acc_log [64];
  int acc_n = 0;
  int ack_log [64];
  int ack_n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thread_dispatch_seq #(.N_CH(N_CH), .PRIO_W(PW), .WORD_W(WW)) u_thread_dispatch_seq (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .req_prio(req_prio), .vec_base(BASE),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .core_start(core_start), .core_pc(core_pc), .core_r1(core_r1), .core_opcode(core_opcode),
    .core_run(core_run), .core_boundary(core_boundary), .core_pc_now(core_pc_now),
    .core_r1_now(core_r1_now), .core_end(core_end), .dispatch_ack(dispatch_ack),
    .idle(idle), .cur_prio(cur_prio));

  function automatic logic [15:0] memw(input logic [15:0] a);
    return (a * 16'd3 + 16'h0400) & 16'hFFFE;
  endfunction

  // Memory responder and access/ack logger, 1 ns after each falling edge.
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      bus_rdata = memw(bus_addr);
      if (bus_valid) begin
        if (wcnt < wait_n) begin bus_ready = 0; wcnt++; end
        else begin
          bus_ready = 1; wcnt = 0;
          if (acc_n < 64) acc_log[acc_n] = bus_addr;
          acc_n++;
        end
      end else bus_ready = 0;
      for (int i = 0; i < N_CH; i++)
        if (dispatch_ack[i]) begin if (ack_n < 64) ack_log[ack_n] = i; ack_n++; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic clr_logs(); acc_n = 0; ack_n = 0; endtask

  task automatic set_prio(input int ch, input int p);
    req_prio[ch*PW +: PW] = PW'(p);
  endtask

  task automatic pulse(input logic [N_CH-1:0] m);
    @(negedge clk); req_pulse = m;
    @(negedge clk); req_pulse = '0;
  endtask

  task automatic wait_start(output logic [15:0] pc, output logic [15:0] r1,
                            output logic [15:0] op, output int cyc);
    cyc = 0; pc = 0; r1 = 0; op = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); cyc++;
      if (core_start) begin pc = core_pc; r1 = core_r1; op = core_opcode; return; end
    end
    cyc = -1;
  endtask

  task automatic end_thread();
    @(negedge clk); core_end = 1;
    @(negedge clk); core_end = 0;
  endtask

  task automatic boundary(input logic [15:0] pc, input logic [15:0] r1);
    @(negedge clk); core_boundary = 1; core_pc_now = pc; core_r1_now = r1;
    @(negedge clk); core_boundary = 0;
  endtask

  task automatic t_reset();
    chk(idle == 1, "R8 idle", idle, 1);
    chk(bus_valid == 0 && core_start == 0 && core_run == 0, "R8 quiet", bus_valid, 0);
    chk(cur_prio == 0, "R8 prio", cur_prio, 0);
  endtask

  task automatic t_single();
    logic [15:0] pc, r1, op; int c;
    set_prio(2, 3); clr_logs(); wait_n = 0;
    pulse(8'h04); wait_start(pc, r1, op, c);
    chk(acc_n == 3, "R1 count", acc_n, 3);
    chk(acc_log[0] == BASE + 16'd8, "R1 addr pc", acc_log[0], BASE + 8);
    chk(acc_log[1] == BASE + 16'd10, "R1 addr r1", acc_log[1], BASE + 10);
    chk(acc_log[2] == memw(BASE + 16'd8), "R1 addr op", acc_log[2], memw(BASE + 8));
    chk(pc == memw(BASE + 16'd8) && r1 == memw(BASE + 16'd10), "R1 regs", pc, memw(BASE + 8));
    chk(op == memw(memw(BASE + 16'd8)), "R1 opcode", op, memw(memw(BASE + 8)));
    chk(c == 4, "R1 latency", c, 4);
    chk(cur_prio == 3 && ack_n == 1 && ack_log[0] == 2, "R3 ack ch2", ack_log[0], 2);
    end_thread();
    chk(idle == 1 && bus_valid == 0, "R7 idle after end", idle, 1);
  endtask

  task automatic t_waits();
    logic [15:0] pc, r1, op; int c;
    set_prio(5, 1); clr_logs(); wait_n = 2;
    pulse(8'h20); wait_start(pc, r1, op, c);
    chk(c == 10, "R2 wait latency", c, 10);
    chk(acc_n == 3 && acc_log[1] == BASE + 16'd22, "R2 addr under wait", acc_log[1], BASE + 22);
    chk(pc == memw(BASE + 16'd20) && r1 == memw(BASE + 16'd22), "R2 data under wait", r1, memw(BASE + 22));
    wait_n = 0; end_thread();
    chk(idle == 1, "R7 idle", idle, 1);
  endtask

  task automatic t_arb();
    logic [15:0] pc, r1, op; int c;
    set_prio(1, 4); set_prio(6, 4); set_prio(3, 2); clr_logs();
    pulse(8'h4A);
    wait_start(pc, r1, op, c);
    chk(pc == memw(BASE + 16'd4), "R3 tie low index", pc, memw(BASE + 4));
    end_thread(); wait_start(pc, r1, op, c);
    chk(pc == memw(BASE + 16'd24), "R3 second", pc, memw(BASE + 24));
    end_thread(); wait_start(pc, r1, op, c);
    chk(cur_prio == 2, "R3 third prio", cur_prio, 2);
    chk(ack_n == 3 && ack_log[0] == 1 && ack_log[1] == 6 && ack_log[2] == 3, "R3 order", ack_log[1], 6);
    end_thread();
    chk(idle == 1, "R7 idle", idle, 1);
  endtask

  task automatic t_preempt();
    logic [15:0] pc, r1, op; int c;
    set_prio(0, 2); set_prio(4, 2); set_prio(7, 6);
    pulse(8'h01); wait_start(pc, r1, op, c);
    pulse(8'h10); boundary(16'h0BE0, 16'h5555);
    chk(bus_valid == 0 && core_run == 1, "R4 equal no preempt", bus_valid, 0);
    pulse(8'h80); clr_logs();
    @(negedge clk); core_boundary = 1; core_pc_now = 16'h0BE0; core_r1_now = 16'h5555;
    @(negedge clk); core_boundary = 0;
    chk(bus_valid == 1 && bus_addr == BASE + 16'd28, "R4 vector next cycle", bus_addr, BASE + 28);
    wait_start(pc, r1, op, c);
    chk(pc == memw(BASE + 16'd28) && cur_prio == 6, "R4 preemptor", pc, memw(BASE + 28));
    clr_logs(); end_thread(); wait_start(pc, r1, op, c);
    chk(acc_n == 1 && acc_log[0] == 16'h0BE0, "R5 single refetch", acc_n, 1);
    chk(pc == 16'h0BE0 && r1 == 16'h5555 && op == memw(16'h0BE0), "R5 context", pc, 16'h0BE0);
    chk(cur_prio == 2, "R6 equal pending waits", cur_prio, 2);
    end_thread(); wait_start(pc, r1, op, c);
    chk(pc == memw(BASE + 16'd16), "R6 pending after resume", pc, memw(BASE + 16));
    end_thread();
    chk(idle == 1, "R7 idle", idle, 1);
  endtask

  task automatic t_higher_pending();
    logic [15:0] pc, r1, op; int c;
    set_prio(0, 1); set_prio(1, 3); set_prio(2, 5);
    pulse(8'h01); wait_start(pc, r1, op, c);
    pulse(8'h02); boundary(16'h0440, 16'h1111); wait_start(pc, r1, op, c);
    pulse(8'h04); end_thread(); wait_start(pc, r1, op, c);
    chk(pc == memw(BASE + 16'd8) && cur_prio == 5, "R6 higher pending first", pc, memw(BASE + 8));
    end_thread(); wait_start(pc, r1, op, c);
    chk(pc == 16'h0440 && r1 == 16'h1111 && cur_prio == 1, "R5 resume after", pc, 16'h0440);
    end_thread();
    chk(idle == 1, "R7 idle", idle, 1);
  endtask

  task automatic t_nest();
    logic [15:0] pc, r1, op; int c;
    for (int i = 0; i < N_CH; i++) set_prio(i, i);
    pulse(8'h01); wait_start(pc, r1, op, c);
    for (int k = 1; k < N_CH; k++) begin
      pulse(N_CH'(1) << k);
      boundary(16'h2000 + 16'(k * 16), 16'h7000 + 16'(k));
      wait_start(pc, r1, op, c);
      chk(cur_prio == PW'(k), "R9 nest level", cur_prio, k);
    end
    for (int k = N_CH - 1; k >= 1; k--) begin
      end_thread(); wait_start(pc, r1, op, c);
      chk(pc == 16'h2000 + 16'(k * 16) && r1 == 16'h7000 + 16'(k) && cur_prio == PW'(k - 1),
          "R9 unwind order", pc, 16'h2000 + k * 16);
    end
    end_thread();
    chk(idle == 1, "R7 idle after unwind", idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_waits();
    t_arb();
    t_preempt();
    t_higher_pending();
    t_nest();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule